// File: doc/BRIEF.md
# Rotating Slice Sequencer for a Time-Interleaved SAR Converter

This block runs the digital side of a time-interleaved successive-approximation converter. There are RES_W+1 converter slices. Each slice needs seven master-clock periods for one conversion: one period to sample and RES_W periods to resolve bits. The sequencer starts the slices in rotation, one clock apart, so that one slice finishes on every clock. It then routes the finished slice's code to a single registered output, which delivers one code per master clock.

Each slice is modelled as a digital code source on a flattened input bus. A one-hot ring produces the per-slice start strobes. The ring position, rotated by one place, goes through a binary encoder. The encoder output selects the slice that is finishing in the current cycle. A warm-up counter keeps the output valid flag low until the first slice has completed.

Top module: `tiadc_seq`

## Requirements
- R1: While rst_ni is low, and at all times, start_o has at most one bit set. Its width is RES_W+1, one bit per slice.
- R2: In the first clock cycle after rst_ni is released, start_o is 0000001 (slice 0). On each later clock the set bit moves from slice k to slice k+1, and slice RES_W wraps to slice 0.
- R3: Every slice receives exactly one start strobe in each window of RES_W+1 consecutive cycles.
- R4: Cycles are counted from the first start (cycle 0). valid_o is low in cycles 0 to RES_W. It is high in cycle RES_W+1 and in every later cycle until the next reset.
- R5: Slice k, as bits [k*RES_W +: RES_W] of slice_code_i, presents its code in cycle t+RES_W if it was started in cycle t. code_o in cycle t+RES_W+1 equals that value.
- R6: The codes of slices that are not finishing in a cycle have no effect on code_o.
- R7: Driving rst_ni low clears start_o, valid_o and code_o to zero at once, without waiting for a clock edge. The sequence restarts at R2 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slice_code_i | input | (RES_W+1)*RES_W | Finished codes of all slices, slice k in bits [k*RES_W +: RES_W] |
| start_o | output | RES_W+1 | Per-slice sample/start strobes, one-hot |
| code_o | output | RES_W | Merged registered output code |
| valid_o | output | 1 | code_o holds a finished conversion |

## Verification
If the ring loses or duplicates its token, the fault shows on start_o in the same cycle. A wrong encoder or select also shows within one cycle. code_o then carries another slice's value, and the bench exposes this by driving random values on every slice that is not finishing. A warm-up counter that is off by one moves the rising edge of valid_o by a cycle relative to the first start.

// File: rtl/tiadc_pkg.sv
package tiadc_pkg;
  parameter int unsigned DEF_RES_W = 6;
endpackage

// File: rtl/tiadc_ring.sv
module tiadc_ring #(
  parameter int unsigned NS = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [NS-1:0] ring_o,
  output logic          done_vld_o
);
  localparam int unsigned CW = $clog2(NS);
  localparam logic [CW-1:0] FILL_MAX = CW'(NS-1);

  logic [NS-1:0] ring_q;
  logic [CW-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q <= '0;
      fill_q <= '0;
    end else if (ring_q == '0) begin
      ring_q <= NS'(1);
    end else begin
      ring_q <= {ring_q[NS-2:0], ring_q[NS-1]};
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
    end
  end

  assign ring_o     = ring_q;
  assign done_vld_o = (ring_q != '0) && (fill_q == FILL_MAX);

  // R1
  ring_onehot_chk: assert property (@(posedge clk_i) $onehot0(ring_q));

  // R2
  ring_rotate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_q != '0) |=> (ring_q == $past({ring_q[NS-2:0], ring_q[NS-1]})));
endmodule

// File: rtl/tiadc_enc.sv
module tiadc_enc #(
  parameter int unsigned NS = 7,
  localparam int unsigned IW = $clog2(NS)
) (
  input  logic [NS-1:0] onehot_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NS; i++) begin
      if (onehot_i[i]) idx_o = idx_o | IW'(i);
    end
  end

  // R5
  always_comb begin
    if ($onehot(onehot_i)) begin
      enc_match_chk: assert (onehot_i[idx_o]);
    end
  end
endmodule

// File: rtl/tiadc_outreg.sv
module tiadc_outreg #(
  parameter int unsigned NS    = 7,
  parameter int unsigned RES_W = 6,
  localparam int unsigned IW = $clog2(NS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IW-1:0]       sel_i,
  input  logic                done_vld_i,
  input  logic [NS*RES_W-1:0] codes_i,
  output logic [RES_W-1:0]    code_o,
  output logic                valid_o
);
  logic [RES_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int k = 0; k < NS; k++) begin
      if (sel_i == IW'(k)) pick = codes_i[k*RES_W +: RES_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= done_vld_i;
      if (done_vld_i) code_o <= pick;
    end
  end

  // R4
  valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
endmodule

// File: rtl/tiadc_seq.sv
module tiadc_seq
  import tiadc_pkg::*;
#(
  parameter int unsigned RES_W = DEF_RES_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [(RES_W+1)*RES_W-1:0]    slice_code_i,
  output logic [RES_W:0]                start_o,
  output logic [RES_W-1:0]              code_o,
  output logic                          valid_o
);
  localparam int unsigned NS = RES_W + 1;
  localparam int unsigned IW = $clog2(NS);

  logic [NS-1:0] ring;
  logic          done_vld;
  logic [IW-1:0] done_sel;

  tiadc_ring #(.NS(NS)) u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ring_o     (ring),
    .done_vld_o (done_vld)
  );

  // slice finishing now was started NS-1 cycles ago: one ring step ahead
  tiadc_enc #(.NS(NS)) u_enc (
    .onehot_i ({ring[NS-2:0], ring[NS-1]}),
    .idx_o    (done_sel)
  );

  tiadc_outreg #(.NS(NS), .RES_W(RES_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (done_sel),
    .done_vld_i (done_vld),
    .codes_i    (slice_code_i),
    .code_o     (code_o),
    .valid_o    (valid_o)
  );

  assign start_o = ring;

  // R4
  valid_needs_ring_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (start_o != '0));
endmodule

// File: tb/tiadc_seq_test.sv
module tiadc_seq_test;
  localparam int RES_W = 6;
  localparam int NS    = RES_W + 1;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [NS*RES_W-1:0]   slice_code_i = '0;
  logic [NS-1:0]         start_o;
  logic [RES_W-1:0]      code_o;
  logic                  valid_o;

  int checks = 0;
  int fails  = 0;
  logic [RES_W-1:0] sb_q[$];

  always #2 clk_i = ~clk_i;

  tiadc_seq #(.RES_W(RES_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .slice_code_i(slice_code_i),
    .start_o(start_o), .code_o(code_o), .valid_o(valid_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [RES_W-1:0] pat(input int t, input int run);
    case (t % 4)
      0: return '0;
      1: return '1;
      2: return (run == 0) ? 6'h2a : 6'h15;
      default: return RES_W'(t * 7 + run);
    endcase
  endfunction

  // driver pushes expected code; monitor pops it one cycle later
  task automatic run_seq(input int ncyc, input int run);
    sb_q.delete();
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int t = 0; t < ncyc; t++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      // R2 R3: token position
      chk("R2", start_o, 32'(1) << (t % NS));
      // R4: warm-up
      chk("R4", valid_o, (t >= NS) ? 1 : 0);
      if (t >= NS) begin
        logic [RES_W-1:0] e;
        e = (sb_q.size() != 0) ? sb_q.pop_front() : '0;
        // R5 R6: selected slice only
        chk("R5", code_o, e);
      end
      for (int k = 0; k < NS; k++) begin
        slice_code_i[k*RES_W +: RES_W] = RES_W'($urandom);
      end
      if (t >= NS - 1) begin
        int d;
        logic [RES_W-1:0] v;
        d = (t + 1) % NS;
        v = pat(t, run);
        slice_code_i[d*RES_W +: RES_W] = v;
        sb_q.push_back(v);
      end
    end
  endtask

  initial begin
    #1;
    // R1 R7: reset state
    @(negedge clk_i);
    chk("R1", start_o, 0);
    chk("R7", valid_o, 0);
    chk("R7", code_o, 0);
    run_seq(60, 0);
    // R7: asynchronous clear mid-cycle
    #1;
    rst_ni = 1'b0;
    #0.5;
    chk("R7", start_o, 0);
    chk("R7", valid_o, 0);
    chk("R7", code_o, 0);
    @(negedge clk_i);
    chk("R1", start_o, 0);
    run_seq(45, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule